// File: doc/BRIEF.md
# Two-Port Shared RAM with Contention Arbitration

This block is a 2048-word by 8-bit memory that two agents, called left and right, use at the same time on one clock. Each side has its own address, write data, read data, active-low enable, read/write select and active-low output enable, and either side may reach any word. When both sides touch the same word in one cycle and at least one of them writes, the block picks a winner and raises a busy flag toward the loser. A write from a busy side is dropped. Reads always proceed.

Two reserved words at the top of the address space act as mailboxes. A write by one side sets a flag toward the other side, and a read by the receiving side clears that flag. A mode input puts the block into follower mode. In that mode the busy flags come in from an external arbiter, so that several of these blocks can sit side by side to form a wider word.

Top module: `dual_port_ram`

## Requirements
- R1: A side with enable low and read/write low writes its data to its address at the clock edge unless its effective busy is high. A side with enable low, read/write high and output enable low presents the addressed word on its read data one clock later.
- R2: Read data is zero in the cycle after any access cycle where enable was high, where output enable was high, or where the side wrote. Output enable is sampled in the access cycle.
- R3: Both sides reading the same address in one cycle raise no busy, and both receive the stored word.
- R4: In leader mode (mode input low), both sides enabled on the same address with at least one writing is a conflict. In that cycle, combinationally, exactly the losing side's busy output is high. Busy is low at all other times.
- R5: A side is the incumbent when it was enabled on that same address in the previous cycle. The right side wins only if it is the incumbent and the left side is not. In every other case the left side wins.
- R6: A write from a side whose effective busy is high leaves memory unchanged. A read from a busy side still proceeds and returns the word as it was before that cycle's writes.
- R7: The left interrupt flag goes high the cycle after a committed right write to 0x7FF. It goes low the cycle after a left read of 0x7FF (enable low, read/write high). A set and a clear in the same cycle leave the flag set.
- R8: The right interrupt flag follows the same rules as R7 with the roles swapped, on address 0x7FE.
- R9: In follower mode (mode input high), effective busy is the busy input of each side, both busy outputs stay low, and internal arbitration is not applied. If both sides commit a write to the same address, the left data remains.
- R10: A side whose enable is high makes no access, raises no busy, and causes no busy on the other side.
- R11: After reset both interrupt flags and both read data outputs are zero, and neither side counts as an incumbent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rstN | input | 1 | Asynchronous reset, active low |
| slaveMode | input | 1 | 1 = busy taken from inputs (follower), 0 = internal arbitration |
| ceNL | input | 1 | Left enable, active low |
| rwNL | input | 1 | Left select, 1 read, 0 write |
| oeNL | input | 1 | Left output enable, active low |
| addrL | input | 11 | Left address |
| wdataL | input | 8 | Left write data |
| rdataL | output | 8 | Left read data, registered |
| busyInL | input | 1 | Left busy from external arbiter (follower mode) |
| busyOutL | output | 1 | Left busy from internal arbitration |
| intL | output | 1 | Left mailbox flag (address 0x7FF) |
| ceNR | input | 1 | Right enable, active low |
| rwNR | input | 1 | Right select, 1 read, 0 write |
| oeNR | input | 1 | Right output enable, active low |
| addrR | input | 11 | Right address |
| wdataR | input | 8 | Right write data |
| rdataR | output | 8 | Right read data, registered |
| busyInR | input | 1 | Right busy from external arbiter (follower mode) |
| busyOutR | output | 1 | Right busy from internal arbitration |
| intR | output | 1 | Right mailbox flag (address 0x7FE) |

## Verification
Arbitration and the mailbox can both act in one cycle: one side writes a mailbox word while the other side reads it. Whether the flag gets set then depends on which side wins. Directed sequences aim both sides at 0x7FE, 0x7FF and a few ordinary words, both from an idle start and with one side already sitting on the address. Random traffic drawn from a small address pool keeps producing such overlaps. A bench model of arbitration, incumbency, read-first memory and flag set/clear predicts busy within the cycle and read data and flags one edge later.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef struct packed {
    logic wrL;
    logic wrR;
    logic rdL;
    logic rdR;
  } dprStrobe_t;
endpackage

// File: rtl/dpr_ctrl.sv
module dpr_ctrl
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic              ceNL,
  input  logic              rwNL,
  input  logic              oeNL,
  input  logic [ADDR_W-1:0] addrL,
  input  logic              busyInL,
  input  logic              ceNR,
  input  logic              rwNR,
  input  logic              oeNR,
  input  logic [ADDR_W-1:0] addrR,
  input  logic              busyInR,
  output dprStrobe_t        strb,
  output logic              busyOutL,
  output logic              busyOutR,
  output logic              intL,
  output logic              intR
);
  localparam logic [ADDR_W-1:0] MBOX_L = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] MBOX_R = MBOX_L - 1'b1;

  logic actL, actR, conflict, incL, incR, rightWins;
  logic arbBusyL, arbBusyR, effBusyL, effBusyR;
  logic prevActL, prevActR;
  logic [ADDR_W-1:0] prevAddrL, prevAddrR;
  logic setIntL, clrIntL, setIntR, clrIntR;

  always_comb begin
    actL      = !ceNL;
    actR      = !ceNR;
    conflict  = actL && actR && (addrL == addrR) && (!rwNL || !rwNR);
    incL      = prevActL && (prevAddrL == addrL);
    incR      = prevActR && (prevAddrR == addrR);
    rightWins = incR && !incL;
    arbBusyL  = conflict && rightWins;
    arbBusyR  = conflict && !rightWins;
    effBusyL  = slaveMode ? busyInL : arbBusyL;
    effBusyR  = slaveMode ? busyInR : arbBusyR;
    busyOutL  = !slaveMode && arbBusyL;
    busyOutR  = !slaveMode && arbBusyR;
    strb.wrL  = actL && !rwNL && !effBusyL;
    strb.wrR  = actR && !rwNR && !effBusyR;
    strb.rdL  = actL && rwNL && !oeNL;
    strb.rdR  = actR && rwNR && !oeNR;
    setIntL   = strb.wrR && (addrR == MBOX_L);
    clrIntL   = actL && rwNL && (addrL == MBOX_L);
    setIntR   = strb.wrL && (addrL == MBOX_R);
    clrIntR   = actR && rwNR && (addrR == MBOX_R);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevActL  <= 1'b0;
      prevActR  <= 1'b0;
      prevAddrL <= '0;
      prevAddrR <= '0;
    end else begin
      prevActL  <= actL;
      prevActR  <= actR;
      prevAddrL <= addrL;
      prevAddrR <= addrR;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intL <= 1'b0;
      intR <= 1'b0;
    end else begin
      if (setIntL)      intL <= 1'b1;
      else if (clrIntL) intL <= 1'b0;
      if (setIntR)      intR <= 1'b1;
      else if (clrIntR) intR <= 1'b0;
    end
  end

  AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rstN)
    !(busyOutL && busyOutR)); // R4
  AST_SAME_READS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (!ceNL && !ceNR && rwNL && rwNR && addrL == addrR) |-> (!busyOutL && !busyOutR)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (ceNL || ceNR) |-> (!busyOutL && !busyOutR)); // R10
  AST_MBOX_SET_L: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrR && addrR == MBOX_L) |=> intL); // R7
  AST_MBOX_SET_R: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrL && addrL == MBOX_R) |=> intR); // R8
  AST_SLAVE_NO_BUSY_OUT: assert property (@(posedge clk) disable iff (!rstN)
    slaveMode |-> (!busyOutL && !busyOutR)); // R9
endmodule

// File: rtl/dpr_datapath.sv
module dpr_datapath
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dprStrobe_t        strb,
  input  logic [ADDR_W-1:0] addrL,
  input  logic [ADDR_W-1:0] addrR,
  input  logic [DATA_W-1:0] wdataL,
  input  logic [DATA_W-1:0] wdataR,
  output logic [DATA_W-1:0] rdataL,
  output logic [DATA_W-1:0] rdataR
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PORTS = 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] portAddr [PORTS];
  logic              portRd   [PORTS];

  assign portAddr[0] = addrL;
  assign portAddr[1] = addrR;
  assign portRd[0]   = strb.rdL;
  assign portRd[1]   = strb.rdR;

  // right first, so a left write to the same word lands last
  always_ff @(posedge clk) begin
    if (strb.wrR) mem[addrR] <= wdataR;
    if (strb.wrL) mem[addrL] <= wdataL;
  end

  for (genvar p = 0; p < PORTS; p++) begin : gPort
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          q <= '0;
      else if (portRd[p]) q <= mem[portAddr[p]];
      else                q <= '0;
    end
  end

  assign rdataL = gPort[0].q;
  assign rdataR = gPort[1].q;

  AST_RD_ZERO_L: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdL |=> (rdataL == '0)); // R2
  AST_RD_ZERO_R: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdR |=> (rdataR == '0)); // R2
endmodule

// File: rtl/dual_port_ram.sv
module dual_port_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic              ceNL,
  input  logic              rwNL,
  input  logic              oeNL,
  input  logic [ADDR_W-1:0] addrL,
  input  logic [DATA_W-1:0] wdataL,
  output logic [DATA_W-1:0] rdataL,
  input  logic              busyInL,
  output logic              busyOutL,
  output logic              intL,
  input  logic              ceNR,
  input  logic              rwNR,
  input  logic              oeNR,
  input  logic [ADDR_W-1:0] addrR,
  input  logic [DATA_W-1:0] wdataR,
  output logic [DATA_W-1:0] rdataR,
  input  logic              busyInR,
  output logic              busyOutR,
  output logic              intR
);
  dprStrobe_t strb;

  dpr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode),
    .ceNL(ceNL), .rwNL(rwNL), .oeNL(oeNL), .addrL(addrL), .busyInL(busyInL),
    .ceNR(ceNR), .rwNR(rwNR), .oeNR(oeNR), .addrR(addrR), .busyInR(busyInR),
    .strb(strb), .busyOutL(busyOutL), .busyOutR(busyOutR),
    .intL(intL), .intR(intR)
  );

  dpr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .addrL(addrL), .addrR(addrR), .wdataL(wdataL), .wdataR(wdataR),
    .rdataL(rdataL), .rdataR(rdataR)
  );
endmodule

// File: tb/dual_port_ram_bench.sv
module dual_port_ram_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slaveMode = 1'b0;
  logic ceNL = 1'b1, rwNL = 1'b1, oeNL = 1'b1, busyInL = 1'b0;
  logic ceNR = 1'b1, rwNR = 1'b1, oeNR = 1'b1, busyInR = 1'b0;
  logic [10:0] addrL = '0, addrR = '0;
  logic [7:0]  wdataL = '0, wdataR = '0;
  logic [7:0]  rdataL, rdataR;
  logic busyOutL, busyOutR, intL, intR;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_port_ram u_dual_port_ram (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode),
    .ceNL(ceNL), .rwNL(rwNL), .oeNL(oeNL), .addrL(addrL), .wdataL(wdataL),
    .rdataL(rdataL), .busyInL(busyInL), .busyOutL(busyOutL), .intL(intL),
    .ceNR(ceNR), .rwNR(rwNR), .oeNR(oeNR), .addrR(addrR), .wdataR(wdataR),
    .rdataR(rdataR), .busyInR(busyInR), .busyOutR(busyOutR), .intR(intR)
  );

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  logic [7:0]  mMem [2048];
  logic        mPrevActL = 1'b0, mPrevActR = 1'b0;
  logic [10:0] mPrevAddrL = '0, mPrevAddrR = '0;
  logic        mIntL = 1'b0, mIntR = 1'b0;
  logic [7:0]  mRdL = '0, mRdR = '0;
  logic        lastBusyL, lastBusyR;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic rightWinsF(input logic [10:0] a);
    logic incL, incR;
    incL = mPrevActL && (mPrevAddrL == a);
    incR = mPrevActR && (mPrevAddrR == a);
    return incR && !incL; // R5
  endfunction

  task automatic setL(input logic en, input logic wr, input logic oe,
                      input logic [10:0] a, input logic [7:0] d);
    ceNL = !en; rwNL = !wr; oeNL = !oe; addrL = a; wdataL = d;
  endtask

  task automatic setR(input logic en, input logic wr, input logic oe,
                      input logic [10:0] a, input logic [7:0] d);
    ceNR = !en; rwNR = !wr; oeNR = !oe; addrR = a; wdataR = d;
  endtask

  task automatic idleBoth();
    setL(1'b0, 1'b0, 1'b0, '0, '0);
    setR(1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  // Called at a falling edge with inputs already driven; returns at the next falling edge.
  task automatic step();
    logic actL, actR, conf, rw, ibL, ibR, ebL, ebR, wrL, wrR, rdL, rdR;
    logic setIL, clrIL, setIR, clrIR;
    actL = !ceNL; actR = !ceNR;
    conf = actL && actR && (addrL == addrR) && (!rwNL || !rwNR);
    rw   = rightWinsF(addrL);
    ibL  = conf && rw;
    ibR  = conf && !rw;
    ebL  = slaveMode ? busyInL : ibL;
    ebR  = slaveMode ? busyInR : ibR;
    #1;
    lastBusyL = busyOutL;
    lastBusyR = busyOutR;
    chk("R4", "busyOutL", busyOutL, !slaveMode && ibL);
    chk("R4", "busyOutR", busyOutR, !slaveMode && ibR);
    wrL = actL && !rwNL && !ebL;
    wrR = actR && !rwNR && !ebR;
    rdL = actL && rwNL && !oeNL;
    rdR = actR && rwNR && !oeNR;
    mRdL = rdL ? mMem[addrL] : 8'h00;
    mRdR = rdR ? mMem[addrR] : 8'h00;
    setIL = wrR && addrR == 11'h7FF;
    clrIL = actL && rwNL && addrL == 11'h7FF;
    setIR = wrL && addrL == 11'h7FE;
    clrIR = actR && rwNR && addrR == 11'h7FE;
    if (setIL) mIntL = 1'b1; else if (clrIL) mIntL = 1'b0;
    if (setIR) mIntR = 1'b1; else if (clrIR) mIntR = 1'b0;
    if (wrR) mMem[addrR] = wdataR;
    if (wrL) mMem[addrL] = wdataL;
    mPrevActL = actL; mPrevAddrL = addrL;
    mPrevActR = actR; mPrevAddrR = addrR;
    @(posedge clk);
    #1;
    chk("R1", "rdataL", rdataL, mRdL);
    chk("R1", "rdataR", rdataR, mRdR);
    chk("R7", "intL", intL, mIntL);
    chk("R8", "intR", intR, mIntR);
    @(negedge clk);
  endtask

  function automatic logic [10:0] pickAddr();
    int sel;
    sel = $urandom_range(0, 7);
    case (sel)
      0: return 11'h7FF;
      1: return 11'h7FE;
      2, 3: return 11'(200 + $urandom_range(0, 2));
      default: return 11'($urandom_range(0, 2047));
    endcase
  endfunction

  initial begin
    int unusedSeed;
    unusedSeed = $urandom(32'd7321);
    for (int i = 0; i < 2048; i++) mMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "rdataL at reset", rdataL, 0);
    chk("R11", "rdataR at reset", rdataR, 0);
    chk("R11", "intL at reset", intL, 0);
    chk("R11", "intR at reset", intR, 0);
    rstN = 1'b1;
    @(negedge clk);

    // fill memory through the left side
    for (int i = 0; i < 2048; i++) begin
      setL(1'b1, 1'b1, 1'b0, 11'(i), 8'(i) ^ 8'h5A);
      setR(1'b0, 1'b0, 1'b0, '0, '0);
      step();
    end
    idleBoth(); step();

    // R3: same-address reads
    setL(1'b1, 1'b0, 1'b1, 11'd10, '0);
    setR(1'b1, 1'b0, 1'b1, 11'd10, '0);
    step();
    chk("R3", "busy on shared read", lastBusyL | lastBusyR, 0);
    chk("R3", "rdataL shared", rdataL, 8'd10 ^ 8'h5A);
    chk("R3", "rdataR shared", rdataR, 8'd10 ^ 8'h5A);

    // R5 tie: fresh write/write, left wins
    idleBoth(); step();
    setL(1'b1, 1'b1, 1'b0, 11'd20, 8'h11);
    setR(1'b1, 1'b1, 1'b0, 11'd20, 8'h22);
    step();
    chk("R5", "tie busyL", lastBusyL, 0);
    chk("R5", "tie busyR", lastBusyR, 1);
    idleBoth(); step();
    setL(1'b1, 1'b0, 1'b1, 11'd20, '0); setR(1'b0, 1'b0, 1'b0, '0, '0);
    step();
    chk("R6", "loser write dropped", rdataL, 8'h11);

    // R5 incumbent: right holds addr 30, left writes there
    idleBoth(); step();
    setR(1'b1, 1'b0, 1'b1, 11'd30, '0); setL(1'b0, 1'b0, 1'b0, '0, '0);
    step();
    setL(1'b1, 1'b1, 1'b0, 11'd30, 8'h33);
    step();
    chk("R5", "incumbent right, busyL", lastBusyL, 1);
    chk("R5", "incumbent right, busyR", lastBusyR, 0);
    idleBoth(); step();
    setL(1'b1, 1'b0, 1'b1, 11'd30, '0);
    step();
    chk("R6", "busy left write dropped", rdataL, 8'd30 ^ 8'h5A);

    // R4 read/write: left writes, right reads, fresh -> right busy, reads old word
    idleBoth(); step();
    setL(1'b1, 1'b1, 1'b0, 11'd40, 8'h44);
    setR(1'b1, 1'b0, 1'b1, 11'd40, '0);
    step();
    chk("R4", "rw busyR", lastBusyR, 1);
    chk("R6", "busy read gets prior word", rdataR, 8'd40 ^ 8'h5A);

    // R7 / R8 mailbox
    idleBoth(); step();
    setR(1'b1, 1'b1, 1'b0, 11'h7FF, 8'h77); step();
    chk("R7", "intL set", intL, 1);
    setR(1'b0, 1'b0, 1'b0, '0, '0);
    setL(1'b1, 1'b0, 1'b1, 11'h7FF, '0); step();
    chk("R7", "intL cleared", intL, 0);
    chk("R7", "mailbox data", rdataL, 8'h77);
    setL(1'b1, 1'b1, 1'b0, 11'h7FE, 8'h66); step();
    chk("R8", "intR set", intR, 1);
    setL(1'b0, 1'b0, 1'b0, '0, '0);
    setR(1'b1, 1'b0, 1'b1, 11'h7FE, '0); step();
    chk("R8", "intR cleared", intR, 0);

    // R10: disabled left on same address
    idleBoth(); step();
    setL(1'b0, 1'b1, 1'b0, 11'd50, 8'hEE);
    setR(1'b1, 1'b1, 1'b0, 11'd50, 8'h55);
    step();
    chk("R10", "no busy with idle side", lastBusyL | lastBusyR, 0);
    idleBoth();
    setL(1'b1, 1'b0, 1'b1, 11'd50, '0); step();
    chk("R10", "idle side wrote nothing", rdataL, 8'h55);

    // R2: output enable off
    setL(1'b1, 1'b0, 1'b0, 11'd50, '0); step();
    chk("R2", "oe off gives zero", rdataL, 0);

    // R9: follower mode
    slaveMode = 1'b1; idleBoth(); step();
    busyInL = 1'b1;
    setL(1'b1, 1'b1, 1'b0, 11'd60, 8'h66); step();
    chk("R9", "busyOutL low in follower mode", lastBusyL, 0);
    busyInL = 1'b0;
    setL(1'b1, 1'b0, 1'b1, 11'd60, '0); step();
    chk("R9", "blocked write", rdataL, 8'd60 ^ 8'h5A);
    setL(1'b1, 1'b1, 1'b0, 11'd61, 8'hA1);
    setR(1'b1, 1'b1, 1'b0, 11'd61, 8'hB2); step();
    idleBoth();
    setR(1'b1, 1'b0, 1'b1, 11'd61, '0); step();
    chk("R9", "double write keeps left", rdataR, 8'hA1);
    slaveMode = 1'b0;

    // constrained random traffic
    for (int blk = 0; blk < 8; blk++) begin
      slaveMode = (blk % 3 == 2);
      for (int n = 0; n < 500; n++) begin
        setL($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 4) != 0,
             pickAddr(), 8'($urandom));
        setR($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 4) != 0,
             pickAddr(), 8'($urandom));
        busyInL = slaveMode && ($urandom_range(0, 3) == 0);
        busyInR = slaveMode && ($urandom_range(0, 3) == 0);
        step();
      end
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end
endmodule